// File: doc/BRIEF.md
# Chained Read-Modify-Write Operation Unit

This block is the execution datapath for the combined operations of an 8-bit accumulator processor. Each operation chains two primitive steps. The memory operand is first shifted, rotated, incremented or decremented and written back. That modified value then feeds a logic, add, subtract or compare step against the accumulator. A second group combines registers with AND: it stores accumulator AND index, loads the accumulator and index together, loads through a mask by the stack pointer, or subtracts from the masked accumulator/index pair. Address generation and bus timing stay with the surrounding core. The core presents the operand, the accumulator (A), index (X) and stack pointer (SP) values, the four incoming flags and a 4-bit operation code, together with a one-cycle `valid_i` strobe.

All results are computed combinationally and captured in registers on the clock edge where `valid_i` is high. A three-state controller governs the registered outputs. `ST_IDLE` is the rest state. In `ST_COMMIT`, a legal operation's write enables and `done_o` are presented for one cycle. In `ST_TRAP`, an undefined code raises `illegal_o` for one cycle with no writes. From every state, the controller moves as follows on each edge: `valid_i` with a legal code goes to `ST_COMMIT` (transition *accept*), `valid_i` with an undefined code goes to `ST_TRAP` (transition *reject*), and no strobe goes to `ST_IDLE` (transition *settle*). Asserting reset returns the controller to `ST_IDLE` (transition *clear*).

Top module: `rmw_alu_top`

## Requirements
- R1: Code 0 (shift-left-then-OR): memory gets operand<<1 with a zero fill, and A gets A OR that value. C is the old operand bit 7, and N/Z come from the new A. Memory and A are written.
- R2: Code 1 (rotate-left-then-AND): memory gets {operand[6:0], C_in}, and A gets A AND that value. C is the old operand bit 7, and N/Z come from the new A. Memory and A are written.
- R3: Code 2 (shift-right-then-XOR): memory gets operand>>1 with a zero fill, and A gets A XOR that value. C is the old operand bit 0, and N/Z come from the new A. Memory and A are written.
- R4: Code 3 (rotate-right-then-add): memory gets R = {C_in, operand[7:1]}. A gets A + R + operand[0] modulo 256. C is the carry out, V is signed overflow of A+R, and N/Z come from the new A. Memory and A are written.
- R5: Code 4 (decrement-then-compare): memory gets operand-1 modulo 256, and A is not written. C is set when A >= that value (unsigned), and N/Z come from A minus that value. V is unchanged.
- R6: Code 5 (increment-then-subtract): memory gets I = operand+1 modulo 256. A gets A - I - (1 - C_in) modulo 256. C is set when no borrow occurs, V is signed overflow, and N/Z come from the new A. Memory and A are written.
- R7: Code 6 (masked store): memory gets A AND X, only memory is written, and all four flags equal their inputs.
- R8: Code 7 loads the operand into A and X. Code 8 loads operand AND SP into A, X and SP. Both take N/Z from the loaded value and leave C and V unchanged.
- R9: Code 9 (masked subtract): X gets (A AND X) - operand modulo 256, and only X is written. C is set when (A AND X) >= operand, N/Z come from the difference, and V is unchanged.
- R10: N is bit 7 of an operation's flag source and Z is set when that source is zero. Any flag an operation does not name equals its input value.
- R11: Codes 10 to 15 are undefined. They produce no write enable and no `done_o`, raise `illegal_o` for exactly one cycle, and return all four flags equal to their inputs.
- R12: Results, write enables and `done_o` appear in the cycle after the `valid_i` edge and last one cycle. A cycle whose previous edge saw no `valid_i` shows no write enable, no `done_o` and no `illegal_o`.
- R13: After reset, all write enables, `done_o`, `illegal_o`, data outputs and flag outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | One-cycle operation strobe |
| op_i | input | 4 | Operation code (0..9 legal) |
| operand_i | input | DATA_W | Memory operand read by the core |
| acc_i | input | DATA_W | Current accumulator |
| idx_i | input | DATA_W | Current index register X |
| sp_i | input | DATA_W | Current stack pointer |
| n_i | input | 1 | Incoming negative flag |
| z_i | input | 1 | Incoming zero flag |
| c_i | input | 1 | Incoming carry flag |
| v_i | input | 1 | Incoming overflow flag |
| mem_data_o | output | DATA_W | Value to write back to memory |
| mem_we_o | output | 1 | Memory write enable |
| acc_o | output | DATA_W | New accumulator |
| acc_we_o | output | 1 | Accumulator write enable |
| idx_o | output | DATA_W | New index register |
| idx_we_o | output | 1 | Index write enable |
| sp_o | output | DATA_W | New stack pointer |
| sp_we_o | output | 1 | Stack pointer write enable |
| n_o | output | 1 | Resulting negative flag |
| z_o | output | 1 | Resulting zero flag |
| c_o | output | 1 | Resulting carry flag |
| v_o | output | 1 | Resulting overflow flag |
| done_o | output | 1 | Legal operation committed (one cycle) |
| illegal_o | output | 1 | Undefined code rejected (one cycle) |

## Verification
The bench builds the block with `DATA_W` = 8, the width the flag and carry rules are written for. At this width, random operands, register values and carry inputs cover the whole byte range, and all sixteen codes, undefined ones included, are reachable. Directed cases reach the wrap points: decrement of 0x00, increment of 0xFF, a rotate-right add that carries out to a zero result, and a masked subtract that borrows. Idle cycles between strobes check the settle transition.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

    localparam int unsigned OP_W     = 4;
    localparam int unsigned OP_LEGAL = 10;

    typedef enum logic [OP_W-1:0] {
        OP_ASL_OR     = 4'd0,
        OP_ROL_AND    = 4'd1,
        OP_LSR_XOR    = 4'd2,
        OP_ROR_ADC    = 4'd3,
        OP_DEC_CMP    = 4'd4,
        OP_INC_SBC    = 4'd5,
        OP_STORE_AX   = 4'd6,
        OP_LOAD_AX    = 4'd7,
        OP_LOAD_SPAND = 4'd8,
        OP_AX_SUB     = 4'd9
    } op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COMMIT = 2'd1,
        ST_TRAP   = 2'd2
    } state_e;

    // destination enable bit positions
    localparam int unsigned WE_MEM = 0;
    localparam int unsigned WE_ACC = 1;
    localparam int unsigned WE_IDX = 2;
    localparam int unsigned WE_SP  = 3;
    localparam int unsigned WE_N   = 4;

endpackage

// File: rtl/rmw_shift_unit.sv
module rmw_shift_unit
    import rmw_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  op_e               op_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [DATA_W-1:0] acc_i,
    input  flags_t            flg_i,
    output logic [DATA_W-1:0] mem_o,
    output logic [DATA_W-1:0] acc_o,
    output flags_t            flg_o
);
    localparam int unsigned SUM_W = DATA_W + 1;

    logic [SUM_W-1:0] sum;

    always_comb begin
        mem_o = operand_i;
        acc_o = acc_i;
        flg_o = flg_i;
        sum   = '0;
        case (op_i)
            OP_ASL_OR: begin
                mem_o   = {operand_i[DATA_W-2:0], 1'b0};
                acc_o   = acc_i | mem_o;
                flg_o.c = operand_i[DATA_W-1];
            end
            OP_ROL_AND: begin
                mem_o   = {operand_i[DATA_W-2:0], flg_i.c};
                acc_o   = acc_i & mem_o;
                flg_o.c = operand_i[DATA_W-1];
            end
            OP_LSR_XOR: begin
                mem_o   = {1'b0, operand_i[DATA_W-1:1]};
                acc_o   = acc_i ^ mem_o;
                flg_o.c = operand_i[0];
            end
            OP_ROR_ADC: begin
                mem_o   = {flg_i.c, operand_i[DATA_W-1:1]};
                // the bit shifted out becomes the carry into the add
                sum     = {1'b0, acc_i} + {1'b0, mem_o} + SUM_W'(operand_i[0]);
                acc_o   = sum[DATA_W-1:0];
                flg_o.c = sum[DATA_W];
                flg_o.v = ~(acc_i[DATA_W-1] ^ mem_o[DATA_W-1])
                        & (acc_i[DATA_W-1] ^ acc_o[DATA_W-1]);
            end
            default: ;
        endcase
        flg_o.n = acc_o[DATA_W-1];
        flg_o.z = (acc_o == '0);
    end

endmodule

// File: rtl/rmw_arith_unit.sv
module rmw_arith_unit
    import rmw_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  op_e               op_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] idx_i,
    input  flags_t            flg_i,
    output logic [DATA_W-1:0] mem_o,
    output logic [DATA_W-1:0] acc_o,
    output logic [DATA_W-1:0] idx_o,
    output flags_t            flg_o
);
    localparam int unsigned SUM_W = DATA_W + 1;

    logic [SUM_W-1:0]  diff;
    logic [DATA_W-1:0] flag_src;
    logic [DATA_W-1:0] masked;

    always_comb begin
        mem_o    = operand_i;
        acc_o    = acc_i;
        idx_o    = idx_i;
        flg_o    = flg_i;
        diff     = '0;
        flag_src = '0;
        masked   = acc_i & idx_i;
        case (op_i)
            OP_DEC_CMP: begin
                mem_o    = operand_i - DATA_W'(1);
                flg_o.c  = (acc_i >= mem_o);
                flag_src = acc_i - mem_o;
            end
            OP_INC_SBC: begin
                mem_o    = operand_i + DATA_W'(1);
                // subtract as add of complement, carry-in is "no borrow"
                diff     = {1'b0, acc_i} + {1'b0, ~mem_o} + SUM_W'(flg_i.c);
                acc_o    = diff[DATA_W-1:0];
                flg_o.c  = diff[DATA_W];
                flg_o.v  = (acc_i[DATA_W-1] ^ mem_o[DATA_W-1])
                         & (acc_i[DATA_W-1] ^ acc_o[DATA_W-1]);
                flag_src = acc_o;
            end
            OP_AX_SUB: begin
                idx_o    = masked - operand_i;
                flg_o.c  = (masked >= operand_i);
                flag_src = idx_o;
            end
            default: ;
        endcase
        flg_o.n = flag_src[DATA_W-1];
        flg_o.z = (flag_src == '0);
    end

endmodule

// File: rtl/rmw_xfer_unit.sv
module rmw_xfer_unit
    import rmw_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  op_e               op_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] idx_i,
    input  logic [DATA_W-1:0] sp_i,
    output logic [DATA_W-1:0] mem_o,
    output logic [DATA_W-1:0] load_o,
    output logic              n_o,
    output logic              z_o
);
    always_comb begin
        mem_o  = acc_i & idx_i;
        load_o = operand_i;
        if (op_i == OP_LOAD_SPAND) begin
            load_o = operand_i & sp_i;
        end
        n_o = load_o[DATA_W-1];
        z_o = (load_o == '0);
    end

endmodule

// File: rtl/rmw_alu_top.sv
module rmw_alu_top
    import rmw_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] idx_i,
    input  logic [DATA_W-1:0] sp_i,
    input  logic              n_i,
    input  logic              z_i,
    input  logic              c_i,
    input  logic              v_i,
    output logic [DATA_W-1:0] mem_data_o,
    output logic              mem_we_o,
    output logic [DATA_W-1:0] acc_o,
    output logic              acc_we_o,
    output logic [DATA_W-1:0] idx_o,
    output logic              idx_we_o,
    output logic [DATA_W-1:0] sp_o,
    output logic              sp_we_o,
    output logic              n_o,
    output logic              z_o,
    output logic              c_o,
    output logic              v_o,
    output logic              done_o,
    output logic              illegal_o
);
    localparam int unsigned WE_W = WE_N;

    op_e    op_cast;
    flags_t flg_in;
    assign op_cast = op_e'(op_i);
    assign flg_in  = '{n: n_i, z: z_i, c: c_i, v: v_i};

    // ---------------- operation units ----------------
    logic [DATA_W-1:0] sh_mem, sh_acc;
    flags_t            sh_flg;
    logic [DATA_W-1:0] ar_mem, ar_acc, ar_idx;
    flags_t            ar_flg;
    logic [DATA_W-1:0] xf_mem, xf_load;
    logic              xf_n, xf_z;

    rmw_shift_unit #(.DATA_W(DATA_W)) u_shift (
        .op_i(op_cast), .operand_i(operand_i), .acc_i(acc_i), .flg_i(flg_in),
        .mem_o(sh_mem), .acc_o(sh_acc), .flg_o(sh_flg)
    );

    rmw_arith_unit #(.DATA_W(DATA_W)) u_arith (
        .op_i(op_cast), .operand_i(operand_i), .acc_i(acc_i), .idx_i(idx_i),
        .flg_i(flg_in), .mem_o(ar_mem), .acc_o(ar_acc), .idx_o(ar_idx),
        .flg_o(ar_flg)
    );

    rmw_xfer_unit #(.DATA_W(DATA_W)) u_xfer (
        .op_i(op_cast), .operand_i(operand_i), .acc_i(acc_i), .idx_i(idx_i),
        .sp_i(sp_i), .mem_o(xf_mem), .load_o(xf_load), .n_o(xf_n), .z_o(xf_z)
    );

    // ---------------- result selection ----------------
    logic [DATA_W-1:0] nx_mem, nx_acc, nx_idx, nx_sp;
    logic [WE_W-1:0]   nx_we;
    flags_t            nx_flg;
    logic              legal;

    always_comb begin
        nx_mem = sh_mem;
        nx_acc = acc_i;
        nx_idx = idx_i;
        nx_sp  = sp_i;
        nx_we  = '0;
        nx_flg = flg_in;
        legal  = 1'b1;
        case (op_i)
            OP_ASL_OR, OP_ROL_AND, OP_LSR_XOR, OP_ROR_ADC: begin
                nx_mem = sh_mem;
                nx_acc = sh_acc;
                nx_flg = sh_flg;
                nx_we[WE_MEM] = 1'b1;
                nx_we[WE_ACC] = 1'b1;
            end
            OP_DEC_CMP: begin
                nx_mem = ar_mem;
                nx_flg = ar_flg;
                nx_we[WE_MEM] = 1'b1;
            end
            OP_INC_SBC: begin
                nx_mem = ar_mem;
                nx_acc = ar_acc;
                nx_flg = ar_flg;
                nx_we[WE_MEM] = 1'b1;
                nx_we[WE_ACC] = 1'b1;
            end
            OP_AX_SUB: begin
                nx_idx = ar_idx;
                nx_flg = ar_flg;
                nx_we[WE_IDX] = 1'b1;
            end
            OP_STORE_AX: begin
                nx_mem = xf_mem;
                nx_we[WE_MEM] = 1'b1;
            end
            OP_LOAD_AX: begin
                nx_acc   = xf_load;
                nx_idx   = xf_load;
                nx_flg.n = xf_n;
                nx_flg.z = xf_z;
                nx_we[WE_ACC] = 1'b1;
                nx_we[WE_IDX] = 1'b1;
            end
            OP_LOAD_SPAND: begin
                nx_acc   = xf_load;
                nx_idx   = xf_load;
                nx_sp    = xf_load;
                nx_flg.n = xf_n;
                nx_flg.z = xf_z;
                nx_we[WE_ACC] = 1'b1;
                nx_we[WE_IDX] = 1'b1;
                nx_we[WE_SP]  = 1'b1;
            end
            default: begin
                legal = 1'b0;
            end
        endcase
    end

    // ---------------- controller ----------------
    state_e state_q, state_d;

    always_comb begin
        if (valid_i) begin
            state_d = legal ? ST_COMMIT : ST_TRAP;   // accept / reject
        end else begin
            state_d = ST_IDLE;                        // settle
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;                       // clear
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- result registers ----------------
    logic [DATA_W-1:0] mem_q, acc_q, idx_q, sp_q;
    logic [WE_W-1:0]   we_q;
    flags_t            flg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
            acc_q <= '0;
            idx_q <= '0;
            sp_q  <= '0;
            we_q  <= '0;
            flg_q <= '0;
        end else if (valid_i) begin
            flg_q <= nx_flg;
            we_q  <= nx_we;
            if (legal) begin
                mem_q <= nx_mem;
                acc_q <= nx_acc;
                idx_q <= nx_idx;
                sp_q  <= nx_sp;
            end
        end
    end

    // ---------------- output process ----------------
    logic committing;

    always_comb begin
        committing = 1'b0;
        done_o     = 1'b0;
        illegal_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_COMMIT: begin
                committing = 1'b1;
                done_o     = 1'b1;
            end
            ST_TRAP:   illegal_o = 1'b1;
            default:   ;
        endcase
        mem_we_o   = committing & we_q[WE_MEM];
        acc_we_o   = committing & we_q[WE_ACC];
        idx_we_o   = committing & we_q[WE_IDX];
        sp_we_o    = committing & we_q[WE_SP];
        mem_data_o = mem_q;
        acc_o      = acc_q;
        idx_o      = idx_q;
        sp_o       = sp_q;
        n_o        = flg_q.n;
        z_o        = flg_q.z;
        c_o        = flg_q.c;
        v_o        = flg_q.v;
    end

    // ---------------- assertions ----------------
    p_illegal_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !(mem_we_o || acc_we_o || idx_we_o || sp_we_o || done_o));

    p_illegal_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> ({n_o, z_o, c_o, v_o} == $past({n_i, z_i, c_i, v_i})));

    p_no_strobe_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(valid_i) |-> !(done_o || illegal_o || mem_we_o || acc_we_o));

    p_store_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(op_i) == OP_STORE_AX)
            |-> ({n_o, z_o, c_o, v_o} == $past({n_i, z_i, c_i, v_i}) && mem_we_o && !acc_we_o));

    p_cmp_keeps_acc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(op_i) == OP_DEC_CMP) |-> (!acc_we_o && mem_we_o && v_o == $past(v_i)));

    p_sub_keeps_v_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(op_i) == OP_AX_SUB) |-> (v_o == $past(v_i) && idx_we_o && !mem_we_o));

    p_done_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, illegal_o}));

endmodule

// File: tb/rmw_alu_top_bench.sv
module rmw_alu_top_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       valid_i = 1'b0;
    logic [3:0] op_i = '0;
    logic [7:0] operand_i = '0, acc_i = '0, idx_i = '0, sp_i = '0;
    logic       n_i = 1'b0, z_i = 1'b0, c_i = 1'b0, v_i = 1'b0;
    logic [7:0] mem_data_o, acc_o, idx_o, sp_o;
    logic       mem_we_o, acc_we_o, idx_we_o, sp_we_o;
    logic       n_o, z_o, c_o, v_o, done_o, illegal_o;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rmw_alu_top #(.DATA_W(8)) u_rmw_alu_top (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .operand_i(operand_i), .acc_i(acc_i), .idx_i(idx_i), .sp_i(sp_i),
        .n_i(n_i), .z_i(z_i), .c_i(c_i), .v_i(v_i),
        .mem_data_o(mem_data_o), .mem_we_o(mem_we_o),
        .acc_o(acc_o), .acc_we_o(acc_we_o),
        .idx_o(idx_o), .idx_we_o(idx_we_o),
        .sp_o(sp_o), .sp_we_o(sp_we_o),
        .n_o(n_o), .z_o(z_o), .c_o(c_o), .v_o(v_o),
        .done_o(done_o), .illegal_o(illegal_o)
    );

    // expected image: mem, a, x, sp, we{sp,x,a,mem}, n z c v, done, illegal
    typedef struct packed {
        logic [7:0] mem;
        logic [7:0] a;
        logic [7:0] x;
        logic [7:0] sp;
        logic [3:0] we;
        logic [3:0] flg;
        logic       done;
        logic       ill;
    } obs_t;

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4: return "R5";
            4'd5: return "R6";
            4'd6: return "R7";
            4'd7, 4'd8: return "R8";
            4'd9: return "R9";
            default: return "R11";
        endcase
    endfunction

    // reference model written from the requirement list
    function automatic obs_t model(input logic [3:0] op, input logic [7:0] m,
                                   input logic [7:0] a, input logic [7:0] x,
                                   input logic [7:0] s, input logic [3:0] fin);
        obs_t e;
        logic n, z, c, v;
        logic [7:0] src, r;
        int t;
        {n, z, c, v} = fin;
        e = '0;
        e.done = 1'b1;
        src = 8'h00;
        case (op)
            4'd0: begin r = {m[6:0], 1'b0}; e.mem = r; e.a = a | r; c = m[7];
                        src = e.a; e.we = 4'b0011; end
            4'd1: begin r = {m[6:0], fin[1]}; e.mem = r; e.a = a & r; c = m[7];
                        src = e.a; e.we = 4'b0011; end
            4'd2: begin r = {1'b0, m[7:1]}; e.mem = r; e.a = a ^ r; c = m[0];
                        src = e.a; e.we = 4'b0011; end
            4'd3: begin r = {fin[1], m[7:1]}; e.mem = r;
                        t = int'(a) + int'(r) + int'(m[0]);
                        e.a = t[7:0]; c = (t > 255);
                        v = (a[7] == r[7]) && (e.a[7] != a[7]);
                        src = e.a; e.we = 4'b0011; end
            4'd4: begin r = m - 8'd1; e.mem = r; c = (a >= r);
                        src = a - r; e.we = 4'b0001; end
            4'd5: begin r = m + 8'd1; e.mem = r;
                        t = int'(a) - int'(r) - (fin[1] ? 0 : 1);
                        e.a = t[7:0]; c = (t >= 0);
                        v = (a[7] != r[7]) && (e.a[7] != a[7]);
                        src = e.a; e.we = 4'b0011; end
            4'd6: begin e.mem = a & x; e.we = 4'b0001; end
            4'd7: begin e.a = m; e.x = m; src = m; e.we = 4'b0110; end
            4'd8: begin r = m & s; e.a = r; e.x = r; e.sp = r; src = r;
                        e.we = 4'b1110; end
            4'd9: begin r = (a & x) - m; e.x = r; c = ((a & x) >= m);
                        src = r; e.we = 4'b0100; end
            default: begin e.done = 1'b0; e.ill = 1'b1; e.we = 4'b0000; end
        endcase
        if (op <= 4'd9 && op != 4'd6) begin
            n = src[7];
            z = (src == 8'h00);
        end
        e.flg = {n, z, c, v};
        return e;
    endfunction

    function automatic obs_t observe();
        obs_t o;
        o.we   = {sp_we_o, idx_we_o, acc_we_o, mem_we_o};
        o.mem  = mem_we_o ? mem_data_o : 8'h00;
        o.a    = acc_we_o ? acc_o : 8'h00;
        o.x    = idx_we_o ? idx_o : 8'h00;
        o.sp   = sp_we_o ? sp_o : 8'h00;
        o.flg  = {n_o, z_o, c_o, v_o};
        o.done = done_o;
        o.ill  = illegal_o;
        return o;
    endfunction

    task automatic check(input string req, input string what, input obs_t act, input obs_t exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one operation: drive on the falling edge, capture edge, sample next falling edge
    task automatic run_op(input logic [3:0] op, input logic [7:0] m, input logic [7:0] a,
                          input logic [7:0] x, input logic [7:0] s, input logic [3:0] fin,
                          input bit idle_after);
        obs_t e, o;
        op_i = op; operand_i = m; acc_i = a; idx_i = x; sp_i = s;
        {n_i, z_i, c_i, v_i} = fin;
        valid_i = 1'b1;
        e = model(op, m, a, x, s, fin);
        @(negedge clk);
        valid_i = 1'b0;
        o = observe();
        // R10 flag pass-through and R12 one-cycle timing are part of every compare
        check(req_of(op), "op result (R10 R12)", o, e);
        if (idle_after) begin
            // scramble inputs: nothing may be committed without a strobe
            op_i = 4'($urandom_range(0, 15)); operand_i = 8'($urandom);
            @(negedge clk);
            o = observe();
            e = '0;
            e.flg = o.flg;
            check("R12", "idle cycle quiet", o, e);
        end
    endtask

    initial begin
        obs_t o, z0;
        void'($urandom(32'd20250112));
        repeat (3) @(negedge clk);
        o = observe();
        z0 = '0;
        // R13: reset state, data outputs included
        tests++;
        if (o !== z0 || mem_data_o !== 8'h00 || acc_o !== 8'h00 || idx_o !== 8'h00
            || sp_o !== 8'h00) begin
            fails++;
            $display("FAIL R13 reset actual=%h/%h/%h/%h/%h expected=0", o, mem_data_o,
                     acc_o, idx_o, sp_o);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // directed corners
        run_op(4'd3, 8'h01, 8'h7F, 8'h00, 8'h00, 4'b0010, 1'b1); // R4 carry out, zero result
        run_op(4'd3, 8'h80, 8'h40, 8'h00, 8'h00, 4'b0000, 1'b0); // R4 signed overflow
        run_op(4'd4, 8'h00, 8'hFF, 8'h11, 8'h22, 4'b0001, 1'b0); // R5 decrement wrap
        run_op(4'd4, 8'h10, 8'h05, 8'h11, 8'h22, 4'b1111, 1'b1); // R5 A below value
        run_op(4'd5, 8'hFF, 8'h80, 8'h00, 8'h00, 4'b0010, 1'b0); // R6 increment wrap
        run_op(4'd5, 8'h00, 8'h80, 8'h00, 8'h00, 4'b0000, 1'b0); // R6 borrow-in, overflow
        run_op(4'd9, 8'h31, 8'hF0, 8'h3C, 8'h00, 4'b0001, 1'b0); // R9 borrow
        run_op(4'd9, 8'h30, 8'hF0, 8'h3C, 8'h00, 4'b0000, 1'b1); // R9 zero difference
        run_op(4'd6, 8'h55, 8'hF0, 8'h3C, 8'h99, 4'b1011, 1'b0); // R7 flags untouched
        run_op(4'd7, 8'h00, 8'h12, 8'h34, 8'h56, 4'b1011, 1'b0); // R8 load zero
        run_op(4'd8, 8'hF3, 8'h12, 8'h34, 8'h9C, 4'b0101, 1'b0); // R8 SP mask
        run_op(4'd1, 8'h80, 8'hFF, 8'h00, 8'h00, 4'b0010, 1'b0); // R2 carry in to bit 0
        run_op(4'd0, 8'h80, 8'h00, 8'h00, 8'h00, 4'b0000, 1'b0); // R1 zero with carry
        run_op(4'd2, 8'h01, 8'h00, 8'h00, 8'h00, 4'b1100, 1'b1); // R3 zero with carry
        run_op(4'd12, 8'hAA, 8'h55, 8'h66, 8'h77, 4'b1010, 1'b1); // R11 undefined
        run_op(4'd15, 8'hAA, 8'h55, 8'h66, 8'h77, 4'b0101, 1'b0); // R11 undefined
        run_op(4'd1, 8'h0F, 8'hFF, 8'h00, 8'h00, 4'b0000, 1'b1);  // after trap: R12

        // constrained random, mostly legal codes
        for (int i = 0; i < 600; i++) begin
            logic [3:0] op;
            op = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(10, 15))
                                              : 4'($urandom_range(0, 9));
            run_op(op, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                   4'($urandom), ($urandom_range(0, 3) == 0));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        tests++;
        $display("FAIL R12 watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule